// File: doc/BRIEF.md
# Signed Packed-Decimal Subtractor

This block takes two signed packed-decimal numbers and produces their difference in the same format, together with a four-bit condition field. Each operand word holds `DIGITS` decimal digits, one per nibble, with the most significant digit at the top of the word. A four-bit sign code sits in the lowest nibble. With the default `DIGITS = 31` the words are 128 bits wide.

A caller presents both operands and a sign-preference bit, then raises `start` for one clock. The block captures the inputs on that edge and computes the difference in sign-magnitude form. It compares the two magnitudes, then either adds them or subtracts the smaller from the larger, using a per-digit decimal carry chain. One edge later it registers the result and pulses `done`.

The condition field is derived from the exact difference, before any truncation. When the exact difference has more digits than the word can hold, the stored value keeps only its low digits. The overflow bit is then set alongside the greater-than or less-than bit.

Top module: `pdec_subtract`

## Requirements
- R1: Sign nibbles 0xA, 0xC, 0xE and 0xF are read as positive and 0xB and 0xD as negative, for both operands. Bits [4*DIGITS+3:4] hold the digits, with the least significant digit in bits [7:4].
- R2: If either operand has a sign nibble in the range 0x0 to 0x9, or any digit nibble above 9, then `cond` is exactly 4'b0001.
- R3: When the exact difference is zero, `cond` is 4'b0010 and all result digits are zero. The result sign nibble is 0xF when the sampled preference bit is 1 and 0xC when it is 0; it is never 0xD.
- R4: When the exact difference is positive and fits, `cond` is 4'b0100. The result sign nibble is 0xF for preference 1 and 0xC for preference 0.
- R5: When the exact difference is negative and fits, `cond` is 4'b1000. The result sign nibble is 0xD whatever the preference bit is.
- R6: When the magnitude of the exact difference is 10^DIGITS or more, `cond` is 4'b0101 for a positive difference and 4'b1001 for a negative one. The result digits are that magnitude modulo 10^DIGITS, and the sign nibble follows R4 or R5.
- R7: For valid operands whose difference fits, the result digits equal the magnitude of minuend minus subtrahend.
- R8: `start` sampled high at a clock edge makes `done` high for exactly one cycle, after the second following edge. The operands and the preference bit are taken only at the edge that samples `start`, so later changes to them have no effect on that result.
- R9: While reset is high at a clock edge, `done`, `cond` and `diff` are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle strobe that captures the operands |
| minuend | input | 4*DIGITS+4 | Number subtracted from |
| subtrahend | input | 4*DIGITS+4 | Number subtracted |
| pos_pref | input | 1 | Positive sign code select: 1 gives 0xF, 0 gives 0xC |
| done | output | 1 | Result valid strobe |
| diff | output | 4*DIGITS+4 | Packed-decimal difference |
| cond | output | 4 | {less, greater, equal, overflow-or-invalid} |

## Verification
The assertions check the following on every cycle:
- the fixed two-edge distance from `start` to `done`;
- the invalid-operand code;
- that a zero result carries zero digits and a non-negative sign;
- that a negative result carries sign 0xD with exclusive flags;
- that a greater-than result carries a positive sign code.

The exact digit values, the truncation on overflow, the choice of positive sign by the preference bit, and the independence from inputs changed after sampling can only be shown by the bench's scenarios. The bench sweeps sign codes, corner magnitudes, strided magnitudes and bad digits on a three-digit configuration, and compares against exact integer arithmetic.

// File: rtl/pdec_pkg.sv
package pdec_pkg;

  typedef enum logic [1:0] {
    SGN_BAD = 2'd0,
    SGN_POS = 2'd1,
    SGN_NEG = 2'd2
  } sgn_class_e;

  localparam logic [3:0] NIB_NEG      = 4'hD;
  localparam logic [3:0] NIB_POS_PREF = 4'hF;
  localparam logic [3:0] NIB_POS_STD  = 4'hC;

  localparam int FLG_LT = 3;
  localparam int FLG_GT = 2;
  localparam int FLG_EQ = 1;
  localparam int FLG_OV = 0;

  function automatic sgn_class_e classify(input logic [3:0] nib);
    sgn_class_e c;
    case (nib)
      4'hA, 4'hC, 4'hE, 4'hF: c = SGN_POS;
      4'hB, 4'hD:             c = SGN_NEG;
      default:                c = SGN_BAD;
    endcase
    return c;
  endfunction

endpackage

// File: rtl/pdec_operand_chk.sv
module pdec_operand_chk #(
  parameter int DIGITS = 31
) (
  input  logic [4*DIGITS+3:0] opnd,
  output logic [4*DIGITS-1:0] mag,
  output logic                neg,
  output logic                ok,
  output logic                zero
);
  import pdec_pkg::*;

  localparam int MW = 4 * DIGITS;

  logic [DIGITS-1:0] dig_bad;
  sgn_class_e        cls;

  for (genvar i = 0; i < DIGITS; i++) begin : g_dig
    assign dig_bad[i] = (opnd[4*i+4 +: 4] > 4'd9);
  end

  assign cls  = classify(opnd[3:0]);
  assign mag  = opnd[MW+3:4];
  assign neg  = (cls == SGN_NEG);
  assign ok   = (cls != SGN_BAD) && ~|dig_bad;
  assign zero = ~|mag;

endmodule

// File: rtl/pdec_magcmp.sv
module pdec_magcmp #(
  parameter int DIGITS = 31
) (
  input  logic [4*DIGITS-1:0] x,
  input  logic [4*DIGITS-1:0] y,
  output logic                gt,
  output logic                eq
);
  // Scan from the most significant digit; the first differing digit decides.
  always_comb begin
    gt = 1'b0;
    eq = 1'b1;
    for (int i = DIGITS - 1; i >= 0; i--) begin
      if (eq) begin
        if (x[4*i +: 4] > y[4*i +: 4]) begin
          gt = 1'b1;
          eq = 1'b0;
        end else if (x[4*i +: 4] < y[4*i +: 4]) begin
          eq = 1'b0;
        end
      end
    end
  end

endmodule

// File: rtl/pdec_bcd_addsub.sv
module pdec_bcd_addsub #(
  parameter int DIGITS = 31
) (
  input  logic [4*DIGITS-1:0] x,
  input  logic [4*DIGITS-1:0] y,
  input  logic                sub,
  output logic [4*DIGITS-1:0] sum,
  output logic                cout
);
  // Subtraction is x + nines-complement(y) + 1; the caller keeps x >= y.
  logic [DIGITS:0] cy;

  assign cy[0] = sub;

  for (genvar i = 0; i < DIGITS; i++) begin : g_d
    logic [3:0] yd;
    logic [4:0] raw;
    assign yd         = sub ? (4'd9 - y[4*i +: 4]) : y[4*i +: 4];
    assign raw        = {1'b0, x[4*i +: 4]} + {1'b0, yd} + {4'b0, cy[i]};
    assign cy[i+1]    = (raw > 5'd9);
    assign sum[4*i +: 4] = cy[i+1] ? (raw[3:0] + 4'd6) : raw[3:0];
  end

  assign cout = cy[DIGITS];

endmodule

// File: rtl/pdec_subtract.sv
module pdec_subtract #(
  parameter int DIGITS = 31
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start,
  input  logic [4*DIGITS+3:0] minuend,
  input  logic [4*DIGITS+3:0] subtrahend,
  input  logic                pos_pref,
  output logic                done,
  output logic [4*DIGITS+3:0] diff,
  output logic [3:0]          cond
);
  import pdec_pkg::*;

  localparam int W  = 4 * DIGITS + 4;
  localparam int MW = 4 * DIGITS;

  // Stage 1: operand capture
  logic         s1_vld;
  logic [W-1:0] s1_a;
  logic [W-1:0] s1_b;
  logic         s1_pref;

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_vld  <= 1'b0;
      s1_a    <= '0;
      s1_b    <= '0;
      s1_pref <= 1'b0;
    end else begin
      s1_vld <= start;
      if (start) begin
        s1_a    <= minuend;
        s1_b    <= subtrahend;
        s1_pref <= pos_pref;
      end
    end
  end

  // Operand decode
  logic [MW-1:0] a_mag, b_mag;
  logic          a_neg, b_neg, a_ok, b_ok, a_zero, b_zero;

  pdec_operand_chk #(.DIGITS(DIGITS)) u_chk_a (
    .opnd(s1_a), .mag(a_mag), .neg(a_neg), .ok(a_ok), .zero(a_zero)
  );
  pdec_operand_chk #(.DIGITS(DIGITS)) u_chk_b (
    .opnd(s1_b), .mag(b_mag), .neg(b_neg), .ok(b_ok), .zero(b_zero)
  );

  // Magnitude compare
  logic a_gt, a_eq;
  pdec_magcmp #(.DIGITS(DIGITS)) u_cmp (
    .x(a_mag), .y(b_mag), .gt(a_gt), .eq(a_eq)
  );

  // Effective operation: differing signs add magnitudes, equal signs subtract
  logic          eff_add, swap;
  logic [MW-1:0] x_mag, y_mag, sum_mag;
  logic          cout;

  assign eff_add = (a_neg != b_neg);
  assign swap    = !eff_add && !(a_gt || a_eq);
  assign x_mag   = swap ? b_mag : a_mag;
  assign y_mag   = swap ? a_mag : b_mag;

  pdec_bcd_addsub #(.DIGITS(DIGITS)) u_add (
    .x(x_mag), .y(y_mag), .sub(!eff_add), .sum(sum_mag), .cout(cout)
  );

  logic       ops_ok, exact_zero, res_neg, ovf;
  logic [3:0] sgn_nib;
  logic [3:0] cond_nxt;
  logic [W-1:0] diff_nxt;

  assign ops_ok     = a_ok && b_ok;
  assign exact_zero = eff_add ? (a_zero && b_zero) : a_eq;
  assign ovf        = eff_add && cout;
  assign res_neg    = !exact_zero && (eff_add ? a_neg : (a_gt ? a_neg : !b_neg));
  assign sgn_nib    = res_neg ? NIB_NEG : (s1_pref ? NIB_POS_PREF : NIB_POS_STD);

  always_comb begin
    cond_nxt = '0;
    if (!ops_ok) begin
      cond_nxt[FLG_OV] = 1'b1;
    end else if (exact_zero) begin
      cond_nxt[FLG_EQ] = 1'b1;
    end else begin
      cond_nxt[FLG_LT] = res_neg;
      cond_nxt[FLG_GT] = !res_neg;
      cond_nxt[FLG_OV] = ovf;
    end
  end

  assign diff_nxt = ops_ok ? {sum_mag, sgn_nib} : '0;

  // Stage 2: result registers
  always_ff @(posedge clk) begin
    if (rst) begin
      done <= 1'b0;
      diff <= '0;
      cond <= '0;
    end else begin
      done <= s1_vld;
      if (s1_vld) begin
        diff <= diff_nxt;
        cond <= cond_nxt;
      end
    end
  end

  // R8
  latency_chk: assert property (@(posedge clk) disable iff (rst)
    start |-> ##2 done);

  // R2
  bad_operand_chk: assert property (@(posedge clk) disable iff (rst)
    (s1_vld && !(a_ok && b_ok)) |=> (cond == 4'b0001));

  // R3
  zero_result_chk: assert property (@(posedge clk) disable iff (rst)
    (done && cond[FLG_EQ]) |->
      (cond == 4'b0010 && diff[W-1:4] == '0 && diff[3:0] != NIB_NEG));

  // R5
  neg_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (done && cond[FLG_LT]) |->
      (diff[3:0] == NIB_NEG && !cond[FLG_GT] && !cond[FLG_EQ]));

  // R4
  pos_sign_chk: assert property (@(posedge clk) disable iff (rst)
    (done && cond[FLG_GT]) |->
      (diff[3:0] == NIB_POS_PREF || diff[3:0] == NIB_POS_STD));

endmodule

// File: tb/sim_pdec_subtract.sv
module sim_pdec_subtract;

  localparam int D   = 3;
  localparam int W   = 4 * D + 4;
  localparam int LIM = 10 ** D;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] minuend = '0;
  logic [W-1:0] subtrahend = '0;
  logic         pos_pref = 1'b0;
  logic         done;
  logic [W-1:0] diff;
  logic [3:0]   cond;

  int total = 0;
  int bad   = 0;

  always #5 clk = ~clk;

  pdec_subtract #(.DIGITS(D)) u0 (
    .clk(clk), .rst(rst), .start(start),
    .minuend(minuend), .subtrahend(subtrahend), .pos_pref(pos_pref),
    .done(done), .diff(diff), .cond(cond)
  );

  function automatic logic [4*D-1:0] to_bcd(input int v);
    logic [4*D-1:0] r;
    int t;
    t = v;
    for (int i = 0; i < D; i++) begin
      r[4*i +: 4] = 4'(t % 10);
      t = t / 10;
    end
    return r;
  endfunction

  function automatic logic [W-1:0] pack(input int m, input logic [3:0] s);
    return {to_bcd(m), s};
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Expected values come from exact integer arithmetic on the operand nibbles.
  task automatic run_op(input logic [W-1:0] a, input logic [W-1:0] b,
                        input logic pref, input string grp);
    bit          valid;
    int          av, bv, d, ad;
    logic [3:0]  ec;
    logic [W-1:0] er;
    string       tag;

    valid = 1'b1;
    av = 0;
    bv = 0;
    for (int i = D - 1; i >= 0; i--) begin
      if (a[4*i+4 +: 4] > 4'd9 || b[4*i+4 +: 4] > 4'd9) valid = 1'b0;
      av = av * 10 + int'(a[4*i+4 +: 4]);
      bv = bv * 10 + int'(b[4*i+4 +: 4]);
    end
    if (a[3:0] < 4'hA || b[3:0] < 4'hA) valid = 1'b0;
    if (a[3:0] == 4'hB || a[3:0] == 4'hD) av = -av;
    if (b[3:0] == 4'hB || b[3:0] == 4'hD) bv = -bv;
    d  = av - bv;
    ad = (d < 0) ? -d : d;
    if (!valid) begin
      ec = 4'b0001; er = '0; tag = "R2";
    end else if (d == 0) begin
      ec = 4'b0010; er = {{(4*D){1'b0}}, pref ? 4'hF : 4'hC}; tag = "R3";
    end else begin
      ec = {d < 0, d > 0, 1'b0, ad >= LIM};
      er = pack(ad % LIM, (d < 0) ? 4'hD : (pref ? 4'hF : 4'hC));
      tag = (ad >= LIM) ? "R6" : ((d < 0) ? "R5" : "R4");
    end

    @(negedge clk);
    check(done == 1'b0, "R8", "done idle before start", W'(done), '0);
    minuend = a; subtrahend = b; pos_pref = pref; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R8: inputs changed after sampling must not matter
    minuend = ~a; subtrahend = ~b; pos_pref = ~pref;
    check(done == 1'b0, "R8", "done one edge after start", W'(done), '0);
    @(negedge clk);
    check(done == 1'b1, "R8", "done two edges after start", W'(done), W'(1));
    check(cond == ec, {grp, " ", tag}, "cond", W'(cond), W'(ec));
    if (valid) begin
      check(diff == er, {grp, " ", (tag == "R4" || tag == "R5") ? "R7" : tag},
            "diff", diff, er);
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int mags[10] = '{0, 1, 2, 9, 10, 99, 100, 500, 998, 999};
    logic [3:0] sg[4] = '{4'hC, 4'hD, 4'hF, 4'hB};

    repeat (3) @(posedge clk);
    @(negedge clk);
    // R9
    check(done == 1'b0 && cond == 4'b0 && diff == '0, "R9", "reset state",
          {diff[W-1:4], cond}, '0);
    rst = 1'b0;

    // R1: every sign code pair, both preference settings
    for (int sa = 0; sa < 16; sa++)
      for (int sb = 0; sb < 16; sb++)
        for (int p = 0; p < 2; p++)
          run_op(pack(123, 4'(sa)), pack(45, 4'(sb)), 1'(p), "R1");

    // Corner magnitudes: zero, one, max, and overflow pairs
    for (int i = 0; i < 10; i++)
      for (int j = 0; j < 10; j++)
        for (int s = 0; s < 4; s++)
          for (int p = 0; p < 2; p++)
            run_op(pack(mags[i], sg[s]), pack(mags[j], sg[(s + j) % 4]), 1'(p), "R7");

    // Strided sweep over the whole magnitude range
    for (int x = 0; x < LIM; x += 53)
      for (int y = 0; y < LIM; y += 47)
        for (int s = 0; s < 4; s++)
          run_op(pack(x, s[0] ? 4'hD : 4'hC), pack(y, s[1] ? 4'hD : 4'hC),
                 1'((x + y + s) % 2), "R6");

    // R2: one bad digit in either operand at each position
    for (int pos = 0; pos < D; pos++)
      for (int v = 10; v < 16; v++) begin
        logic [W-1:0] t;
        t = pack(456, 4'hC);
        t[4*pos+4 +: 4] = 4'(v);
        run_op(t, pack(7, 4'hD), 1'b0, "R2");
        run_op(pack(7, 4'hC), t, 1'b1, "R2");
      end

    @(negedge clk);
    check(done == 1'b0, "R8", "single-cycle done", W'(done), '0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule